// File: doc/BRIEF.md
# Reset Source Recorder with Deferred System Reset

This block sits beside a chip's reset controller and keeps a record of why the system was last reset. Each detector (supply monitors, watchdog, lockup, debug request and others) delivers a one-cycle request pulse on its own bit of a 32-bit request vector. Every system reset rewrites a per-reset status word with the set of causes, and ORs those causes into a sticky word. The sticky word keeps its bits across later system resets until software clears them. Both words carry a derived warm flag.

Software can mark some sources as deferrable. A marked source does not reset the system at once. It raises an interrupt flag, and a fixed grace period starts so that firmware can shut down cleanly. When the period ends, the system reset fires whether or not the flag was cleared. A separate core-only request resets just the processor core and leaves the sticky record alone. Register state is reached through a simple write strobe with a combinational read path over four word addresses.

Top module: `rst_src_recorder`

## Requirements
- R1: While `por_n` is low and after it rises, the per-reset word (address 0) and the sticky word (address 1) both read 0x00000002 (power-on bit 1 only), the enable mask (address 2) and flag word (address 3) read 0, and `sys_rst`, `core_rst` and `rst_irq` are low.
- R2: A system request at a position that is not enabled for deferral makes `sys_rst` and `core_rst` high from the next clock edge for exactly HOLD_CYC (16) cycles.
- R3: When a system reset starts, the per-reset word is replaced by every system source that is pending or requested in that cycle. System source bits: 0 wakeup, 2 low voltage, 3 high voltage, 8 fatal, 9 pin, 10 debug module, 11 reset-controller timeout, 12 stop timeout, 13 clock loss, 14 watchdog, 15 software, 16 lockup, 17 JTAG.
- R4: Bit 4 (warm) of both status words reads 1 exactly when any bit from 31 down to 8 of that word is set.
- R5: The sticky word ORs in the causes of each system reset and keeps them across later system resets. Writing 1s to address 1 clears those bits. A cause recorded in the same cycle as a clear of its bit stays set.
- R6: A request on bit 5 (core-only) makes `core_rst` high for 16 cycles while `sys_rst` stays low. It sets bit 5 of the per-reset word and never sets bit 5 of the sticky word.
- R7: Address 2 (enable mask) stores only bits 9, 10, 12, 14, 15 and 16. All other bits read 0.
- R8: An enabled source sets its flag bit at address 3 and raises `rst_irq` on the next edge. `sys_rst` rises exactly DELAY_CYC (256) cycles after `rst_irq` rose, even if the flag was cleared in the meantime.
- R9: Writing 1s to address 3 clears those flags. A flag requested in the same cycle as its clear stays set. `rst_irq` is high exactly when some flag is set.
- R10: A non-enabled system request during the grace period starts the system reset on the next edge, and the record includes the deferred sources still pending.
- R11: After a system reset, the enable mask and the flags read 0. Requests and register writes made while `sys_rst` is high have no effect.
- R12: Request bits 6, 7 and 18 to 31 are ignored. Writes to address 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| src_req | input | 32 | One-cycle reset request pulses, one bit per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 per-reset, 1 sticky, 2 enable mask, 3 flags |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sys_rst | output | 1 | System reset, active high |
| core_rst | output | 1 | Core reset, active high |
| rst_irq | output | 1 | Reset warning interrupt |

## Verification
Software clears (write-1-to-clear) can land in the same cycle as new hardware sets, on both the sticky word and the flag word. The bench provokes this by driving a request and a clearing write for the same bit in one cycle, for example a fatal request with a sticky clear of bit 8, and a repeated software request with a flag clear of bit 15. It then reads the word back and expects the bit to remain set. A second flag cleared in the same cycle as a new flag is checked to leave only the new one. The start of the grace period is also timed against a later immediate request, and the recorded word must merge both.

// File: rtl/rsr_pkg.sv
`timescale 1ns/1ps
package rsr_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned WARM_LO = 8;

    localparam int unsigned BIT_POR  = 1;
    localparam int unsigned BIT_WARM = 4;
    localparam int unsigned BIT_CORE = 5;

    // system sources: 0,2,3 and 8..17
    localparam logic [WORD_W-1:0] SYS_MASK   = 32'h0003_FF0D;
    // deferrable: pin 9, debug 10, stop timeout 12, watchdog 14, software 15, lockup 16
    localparam logic [WORD_W-1:0] DEFER_MASK = 32'h0001_D600;
    localparam logic [WORD_W-1:0] POR_VAL    = WORD_W'(1) << BIT_POR;

    typedef enum logic [1:0] {
        RA_LAST   = 2'd0,
        RA_STICKY = 2'd1,
        RA_IEN    = 2'd2,
        RA_FLAG   = 2'd3
    } rsr_addr_e;

    function automatic logic [WORD_W-1:0] add_warm(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        r = v;
        r[BIT_WARM] = |v[WORD_W-1:WARM_LO];
        return r;
    endfunction
endpackage

// File: rtl/rsr_timer.sv
`timescale 1ns/1ps
module rsr_timer #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clr_i,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CW = (LEN > 2) ? $clog2(LEN) : 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        done_o = tmr_q.busy && (tmr_q.cnt == '0);
        if (clr_i) begin
            tmr_d.busy = 1'b0;
            tmr_d.cnt  = '0;
        end else if (done_o) begin
            tmr_d.busy = 1'b0;
        end else if (tmr_q.busy) begin
            tmr_d.cnt = tmr_q.cnt - CW'(1);
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(LEN - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && tmr_q.cnt != '0 && !clr_i) |=> (tmr_q.busy && tmr_q.cnt == $past(tmr_q.cnt) - CW'(1)));
endmodule

// File: rtl/rsr_w1c_bank.sv
`timescale 1ns/1ps
module rsr_w1c_bank #(
    parameter int unsigned W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_clr_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] bits_d, bits_q;

    always_comb begin
        if (sync_clr_i) bits_d = '0;
        else            bits_d = set_i | (bits_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= RST_VAL;
        else        bits_q <= bits_d;
    end

    assign q_o = bits_q;

    // R5 R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_clr_i |=> ((bits_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/rst_src_recorder.sv
`timescale 1ns/1ps
module rst_src_recorder
    import rsr_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 256,
    parameter int unsigned HOLD_CYC  = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [WORD_W-1:0] src_req,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sys_rst,
    output logic              core_rst,
    output logic              rst_irq
);
    typedef struct packed {
        logic [WORD_W-1:0] last;
        logic [WORD_W-1:0] ien;
        logic [WORD_W-1:0] pend;
    } rec_t;

    rec_t st_d, st_q;

    logic              hold_busy, hold_done_unused;
    logic              core_busy, core_done_unused;
    logic              dly_busy_unused, dly_done;
    logic [WORD_W-1:0] req_live, sys_req, imm_req, dfr_req, rec_set;
    logic              enter, core_hit, wr_ok;
    logic              wr_sticky, wr_flag, wr_ien;
    logic [WORD_W-1:0] sticky_q, flag_q;
    rsr_addr_e         addr;

    assign addr      = rsr_addr_e'(bus_addr);
    assign req_live  = hold_busy ? '0 : src_req;
    assign sys_req   = req_live & SYS_MASK;
    assign imm_req   = sys_req & ~st_q.ien;
    assign dfr_req   = sys_req & st_q.ien;
    assign rec_set   = st_q.pend | sys_req;
    assign enter     = (|imm_req) | dly_done;
    assign core_hit  = req_live[BIT_CORE];
    assign wr_ok     = bus_wr & ~hold_busy;
    assign wr_sticky = wr_ok && (addr == RA_STICKY);
    assign wr_flag   = wr_ok && (addr == RA_FLAG);
    assign wr_ien    = wr_ok && (addr == RA_IEN);

    always_comb begin
        st_d = st_q;
        if (enter) begin
            st_d.last = rec_set;
            st_d.ien  = '0;
            st_d.pend = '0;
        end else begin
            st_d.pend = st_q.pend | dfr_req;
            if (wr_ien)   st_d.ien = bus_wdata & DEFER_MASK;
            if (core_hit) st_d.last[BIT_CORE] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.last <= POR_VAL;
            st_q.ien  <= '0;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rsr_w1c_bank #(.W(WORD_W), .RST_VAL(POR_VAL)) u_sticky (
        .clk        (clk),
        .rst_n      (por_n),
        .sync_clr_i (1'b0),
        .set_i      (enter ? rec_set : '0),
        .clr_i      (wr_sticky ? bus_wdata : '0),
        .q_o        (sticky_q)
    );

    rsr_w1c_bank #(.W(WORD_W), .RST_VAL('0)) u_flag (
        .clk        (clk),
        .rst_n      (por_n),
        .sync_clr_i (enter),
        .set_i      (dfr_req),
        .clr_i      (wr_flag ? bus_wdata : '0),
        .q_o        (flag_q)
    );

    rsr_timer #(.LEN(DELAY_CYC)) u_delay (
        .clk     (clk),
        .rst_n   (por_n),
        .start_i ((|dfr_req) && !enter),
        .clr_i   (enter),
        .busy_o  (dly_busy_unused),
        .done_o  (dly_done)
    );

    rsr_timer #(.LEN(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst_n   (por_n),
        .start_i (enter),
        .clr_i   (1'b0),
        .busy_o  (hold_busy),
        .done_o  (hold_done_unused)
    );

    rsr_timer #(.LEN(HOLD_CYC)) u_core (
        .clk     (clk),
        .rst_n   (por_n),
        .start_i (core_hit),
        .clr_i   (1'b0),
        .busy_o  (core_busy),
        .done_o  (core_done_unused)
    );

    always_comb begin
        unique case (addr)
            RA_LAST:   bus_rdata = add_warm(st_q.last);
            RA_STICKY: bus_rdata = add_warm(sticky_q);
            RA_IEN:    bus_rdata = st_q.ien;
            default:   bus_rdata = flag_q;
        endcase
    end

    assign sys_rst  = hold_busy;
    assign core_rst = hold_busy | core_busy;
    assign rst_irq  = |flag_q;

    // R11
    post_rst_clean_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> (st_q.ien == '0 && flag_q == '0));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |-> !rst_irq);

    // R5
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$past(wr_sticky) |-> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // R2
    rec_nonempty_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst) |-> (st_q.last & SYS_MASK) != '0);

    // R6
    core_not_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst) && !sys_rst |-> !sticky_q[BIT_CORE]);
endmodule

// File: tb/sim_rst_src_recorder.sv
`timescale 1ns/1ps
module sim_rst_src_recorder;
    localparam logic [31:0] M_SYS  = 32'h0003_FF0D;
    localparam logic [31:0] M_DEF  = 32'h0001_D600;
    localparam logic [31:0] M_CORE = 32'h0000_0020;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst, core_rst, rst_irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rst_src_recorder u0 (
        .clk(clk), .por_n(por_n), .src_req(src_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst(sys_rst), .core_rst(core_rst), .rst_irq(rst_irq)
    );

    function automatic logic [31:0] warmed(input logic [31:0] v);
        return v | (((v & 32'hFFFF_FF00) != 0) ? 32'h10 : 32'h0);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.4;
        v = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] v);
        src_req = v;
        tick();
        src_req = '0;
    endtask

    task automatic pulse_wr(input logic [31:0] v, input logic [1:0] a, input logic [31:0] d);
        src_req = v; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        src_req = '0; bus_wr = 1'b0;
    endtask

    // counts cycles of sys_rst high, starting while it is high
    task automatic hold_out(output int w);
        w = 0;
        while (sys_rst && w < 100) begin
            w++;
            tick();
        end
    endtask

    task automatic wait_rst(output int t);
        int n = 0;
        while (!sys_rst && n < 400) begin
            n++;
            tick();
        end
        t = cyc;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int w, t_irq, t_rst;
        logic [31:0] v, exp_sticky, exp_last;
        logic core_sys_seen;

        void'($urandom(32'd9137));
        repeat (3) tick();
        // R1 during reset
        chk("R1 sys_rst in por", {31'd0, sys_rst}, 32'd0);
        por_n = 1'b1;
        tick();
        rd_chk("R1 last", 2'd0, 32'h2);
        rd_chk("R1 sticky", 2'd1, 32'h2);
        rd_chk("R1 ien", 2'd2, 32'h0);
        rd_chk("R1 flag", 2'd3, 32'h0);
        chk("R1 outs", {29'd0, sys_rst, core_rst, rst_irq}, 32'd0);
        tick();

        // R7 mask width
        wr(2'd2, 32'hFFFF_FFFF);
        rd_chk("R7 ien mask", 2'd2, M_DEF);
        tick();
        wr(2'd2, 32'h0);

        // R12 unmapped request bits and write to address 0
        pulse(32'hFFFC_00C0);
        for (int i = 0; i < 3; i++) begin
            chk("R12 no reset", {30'd0, sys_rst, core_rst}, 32'd0);
            tick();
        end
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk("R12 last kept", 2'd0, 32'h2);
        tick();

        // R2 R3 R4 immediate system reset
        pulse(32'h0000_0104);
        chk("R2 sys_rst rose", {31'd0, sys_rst}, 32'd1);
        chk("R2 core_rst rose", {31'd0, core_rst}, 32'd1);
        hold_out(w);
        chk("R2 hold width", w, 32'd16);
        rd_chk("R3 last record", 2'd0, 32'h114);
        rd_chk("R4 sticky warm", 2'd1, 32'h116);
        tick();

        // R4 wakeup only: no warm
        pulse(32'h1);
        hold_out(w);
        rd_chk("R4 no warm", 2'd0, 32'h1);
        tick();

        // R5 clear and same-cycle set
        wr(2'd1, 32'h6);
        rd_chk("R5 cleared", 2'd1, 32'h111);
        tick();
        pulse_wr(32'h100, 2'd1, 32'h100);
        hold_out(w);
        rd_chk("R5 set wins", 2'd1, 32'h111);
        tick();

        // R6 core-only
        pulse(M_CORE);
        chk("R6 core_rst", {31'd0, core_rst}, 32'd1);
        w = 0;
        core_sys_seen = 1'b0;
        while (core_rst && w < 100) begin
            if (sys_rst) core_sys_seen = 1'b1;
            w++;
            tick();
        end
        chk("R6 core width", w, 32'd16);
        chk("R6 sys stays low", {31'd0, core_sys_seen}, 32'd0);
        rd_chk("R6 last core bit", 2'd0, 32'h130);
        rd(2'd1, v);
        chk("R6 sticky no core", v & M_CORE, 32'h0);
        tick();

        // R8 deferral timing, cleared flag does not cancel
        wr(2'd2, M_DEF);
        pulse(32'h4000);
        chk("R8 irq", {30'd0, rst_irq, sys_rst}, 32'd2);
        t_irq = cyc;
        rd_chk("R8 flag", 2'd3, 32'h4000);
        wr(2'd3, 32'h4000);
        chk("R9 irq cleared", {31'd0, rst_irq}, 32'd0);
        wait_rst(t_rst);
        chk("R8 delay", t_rst - t_irq, 32'd256);
        // R11 stimulus during hold
        pulse_wr(32'h104, 2'd2, M_DEF);
        hold_out(w);
        rd_chk("R11 ien zero", 2'd2, 32'h0);
        rd_chk("R11 flag zero", 2'd3, 32'h0);
        rd_chk("R11 last ignores", 2'd0, 32'h4010);
        rd_chk("R5 sticky accum", 2'd1, 32'h4111);
        tick();

        // R10 immediate during grace period
        wr(2'd2, 32'h200);
        pulse(32'h200);
        chk("R10 irq", {31'd0, rst_irq}, 32'd1);
        repeat (5) tick();
        pulse(32'h4);
        chk("R10 sys_rst", {30'd0, sys_rst, rst_irq}, 32'd2);
        hold_out(w);
        rd_chk("R10 merged", 2'd0, 32'h214);
        tick();

        // R9 same-cycle flag set and clear
        wr(2'd2, M_DEF);
        pulse(32'h8000);
        pulse_wr(32'h8000, 2'd3, 32'h8000);
        rd_chk("R9 set wins", 2'd3, 32'h8000);
        tick();
        pulse_wr(32'h10000, 2'd3, 32'h8000);
        rd_chk("R9 swap", 2'd3, 32'h10000);
        chk("R9 irq any", {31'd0, rst_irq}, 32'd1);
        tick();
        wait_rst(t_rst);
        hold_out(w);
        rd_chk("R3 deferred record", 2'd0, 32'h18010);
        rd(2'd1, v);
        exp_sticky = v & ~32'h10;
        tick();

        // random immediate resets with sticky clears
        for (int it = 0; it < 40; it++) begin
            logic [31:0] r, m;
            r = $urandom & ~M_CORE;
            if ((r & M_SYS) == 0) r = r | 32'h4;
            pulse(r);
            hold_out(w);
            chk("R2 rnd width", w, 32'd16);
            exp_last = warmed(r & M_SYS);
            exp_sticky = exp_sticky | (r & M_SYS);
            rd_chk("R3 rnd last", 2'd0, exp_last);
            rd_chk("R5 rnd sticky", 2'd1, warmed(exp_sticky));
            tick();
            if (($urandom & 1) != 0) begin
                m = $urandom;
                wr(2'd1, m);
                exp_sticky = exp_sticky & ~m;
                rd_chk("R5 rnd clear", 2'd1, warmed(exp_sticky));
                tick();
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule